// File: doc/BRIEF.md
# Multi-Master Doorbell Unit

This block holds a row of doorbell channels that any of up to 32 bus masters can ring. A master rings a channel by writing to that channel's trigger register. The master ID on the bus sideband picks the bit that gets recorded, so the target can tell who rang it. Each target owns a mask of masters it is willing to hear from. The masked view of the recorded rings is its pending word, and the interrupt line for the channel is high while any pending bit is set.

The target services a channel in three steps. It reads the pending word, handles each master named there, and writes the same word back to the pending register. Writing a one to a pending bit clears it. The enable mask can be changed with read-modify-write at any time. Rings from masters that are masked off are still recorded, and they show up as pending once those masters are enabled.

The bus port is a plain single-cycle register interface. A write strobe, an address, write data and a master ID come in. Read data is returned combinationally from the address.

Top module: `db_unit`

## Requirements
- R1: After reset every raw and enable word is zero, every register reads zero and all interrupt lines are low.
- R2: Channel c occupies byte addresses c*STRIDE to c*STRIDE+15. Within that space, offset 0x0 is trigger, 0x4 is enable, 0x8 is raw and 0xC is pending, selected by address bits [3:2]. Address bits [1:0] are ignored. Offsets of 0x10 and above inside a stride, and channels numbered NUM_CH or higher, ignore writes and read zero.
- R3: A write to trigger with write-data bit 0 set records a ring from the writing master by setting bit bus_mid of the raw word on the next clock. A trigger write with bit 0 clear has no effect. Trigger reads as zero. State changes only on writes.
- R4: A ring is recorded in the raw word whether or not the master is enabled.
- R5: The enable register is read/write with one bit per master. Bits at positions NUM_MST and above read zero.
- R6: Pending reads as raw AND enable. Clearing an enable bit hides the recorded ring, and setting it again reveals the ring.
- R7: Writing the pending register clears the raw bits where the write data has ones and leaves the other bits alone. Writes to the raw register are ignored.
- R8: db_irq[c] is the OR of channel c's pending bits. It stays high, with no further action, until those bits are cleared or disabled.
- R9: A trigger write with a master ID of NUM_MST or above records nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_mid | input | 5 | Master ID of the current access |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| db_irq | output | NUM_CH | Per-channel interrupt to the target |

## Verification
The bench rings a channel while its enable bit is off and checks that the ring appears in raw but not in pending. A design that gated the record itself would lose that ring once the master was enabled. It clears one bit of several pending bits, to catch a clear that wipes the whole word, and it writes the raw register to catch a design that lets raw be written. It aims trigger writes at channels past NUM_CH, at the hole above offset 0x0C, and with master IDs past NUM_MST. An address decoder that aliases would ring or enable the wrong channel, and an unguarded shift would set a bit that does not exist.

// File: rtl/db_unit.sv
module db_unit #(
  parameter int NUM_CH  = 4,
  parameter int NUM_MST = 24,
  parameter int STRIDE  = 32,
  parameter int AW      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [4:0]        bus_mid,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] db_irq
);
  localparam int SW = $clog2(STRIDE);
  localparam int CW = AW - SW;

  logic [NUM_CH-1:0][NUM_MST-1:0] raw_q, en_q;

  logic [CW-1:0] ch_idx;
  logic [SW-1:0] ofs;
  logic [1:0]    rsel;
  logic          ofs_ok, mid_ok;
  logic [NUM_MST-1:0] ring_v, wmask;

  assign ch_idx = bus_addr[AW-1:SW];
  assign ofs    = bus_addr[SW-1:0];
  assign rsel   = bus_addr[3:2];
  assign ofs_ok = {1'b0, ofs} < (SW+1)'(16);
  assign mid_ok = {1'b0, bus_mid} < 6'(NUM_MST);
  assign ring_v = (mid_ok && bus_wdata[0]) ? (NUM_MST'(1) << bus_mid) : '0;
  assign wmask  = bus_wdata[NUM_MST-1:0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = bus_we && ofs_ok && (ch_idx == CW'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        raw_q[c] <= '0;
        en_q[c]  <= '0;
      end else if (hit) begin
        case (rsel)
          2'd0: raw_q[c] <= raw_q[c] | ring_v;
          2'd1: en_q[c]  <= wmask;
          2'd3: raw_q[c] <= raw_q[c] & ~wmask;
          default: ;
        endcase
      end
    end

    assign db_irq[c] = |(raw_q[c] & en_q[c]);
  end

  always_comb begin
    bus_rdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ofs_ok && ch_idx == CW'(c)) begin
        case (rsel)
          2'd1: bus_rdata = 32'(en_q[c]);
          2'd2: bus_rdata = 32'(raw_q[c]);
          2'd3: bus_rdata = 32'(raw_q[c] & en_q[c]);
          default: bus_rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/db_unit_chk.sv
module db_unit_chk #(
  parameter int NUM_CH  = 4,
  parameter int NUM_MST = 24,
  parameter int STRIDE  = 32,
  parameter int AW      = 8
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           bus_we,
  input logic [AW-1:0]                  bus_addr,
  input logic [31:0]                    bus_wdata,
  input logic [4:0]                     bus_mid,
  input logic [NUM_CH-1:0]              db_irq,
  input logic [NUM_CH-1:0][NUM_MST-1:0] raw_q,
  input logic [NUM_CH-1:0][NUM_MST-1:0] en_q
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) $rose(rst_n) |-> (db_irq == '0));

  // R3
  idle_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> ($stable(raw_q) && $stable(en_q)));

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(db_irq));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_a
    // R6
    en_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == AW'(c*STRIDE + 4) && bus_wdata == 32'd0) |=> !db_irq[c]);

    // R4
    ring_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == AW'(c*STRIDE) && bus_wdata[0] && ({1'b0, bus_mid} < 6'(NUM_MST)))
      |=> |(raw_q[c] & (NUM_MST'(1) << $past(bus_mid))));
  end
endmodule

bind db_unit db_unit_chk #(.NUM_CH(NUM_CH), .NUM_MST(NUM_MST), .STRIDE(STRIDE), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_mid(bus_mid), .db_irq(db_irq),
  .raw_q(raw_q), .en_q(en_q)
);

// File: tb/test_db_unit.sv
module test_db_unit;
  localparam int NCH = 4, NM = 24, STR = 32, AW = 8;
  localparam logic [31:0] MMASK = (32'd1 << NM) - 1;

  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [4:0] bus_mid = '0;
  logic [NCH-1:0] db_irq;

  int checks = 0, fails = 0;
  logic [31:0] m_raw [NCH];
  logic [31:0] m_en  [NCH];
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  db_unit #(.NUM_CH(NCH), .NUM_MST(NM), .STRIDE(STR), .AW(AW)) i_db_unit (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_mid(bus_mid), .bus_rdata(bus_rdata), .db_irq(db_irq));

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin m_raw[c] <= 0; m_en[c] <= 0; end
    end else if (bus_we) begin
      int ch, of;
      ch = int'(bus_addr) / STR;
      of = int'(bus_addr) % STR;
      if (ch < NCH && of < 16) begin
        case (of / 4)
          0: if (bus_wdata[0] && int'(bus_mid) < NM) m_raw[ch] <= m_raw[ch] | (32'd1 << bus_mid);
          1: m_en[ch] <= bus_wdata & MMASK;
          3: m_raw[ch] <= m_raw[ch] & ~bus_wdata;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] m_read(input logic [AW-1:0] a);
    int ch, of;
    ch = int'(a) / STR;
    of = int'(a) % STR;
    if (ch >= NCH || of >= 16) return 0;
    case (of / 4)
      1: return m_en[ch];
      2: return m_raw[ch];
      3: return m_raw[ch] & m_en[ch];
      default: return 0;
    endcase
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic compare();
    logic [NCH-1:0] ei;
    for (int c = 0; c < NCH; c++) ei[c] = |(m_raw[c] & m_en[c]);
    chk(32'(db_irq), 32'(ei), "R8 irq");
    chk(bus_rdata, m_read(bus_addr), cur_req);
  endtask

  task automatic step(input logic we, input int a, input logic [31:0] d, input int mid, input string req);
    @(negedge clk);
    if (rst_n) compare();
    cur_req = req;
    bus_we = we; bus_addr = AW'(a); bus_wdata = d; bus_mid = 5'(mid);
  endtask

  task automatic rd(input int a, input string req);
    step(1'b0, a, 0, 0, req);
  endtask

  task automatic expect_rd(input int a, input logic [31:0] e, input string req);
    rd(a, req);
    @(negedge clk);
    chk(bus_rdata, e, req);
  endtask

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int c = 0; c < NCH; c++)
      for (int r = 0; r < 4; r++) expect_rd(c*STR + r*4, 0, "R1");
    chk(32'(db_irq), 0, "R1 irq");
    // R5 enable width
    step(1, 1*STR+4, 32'hFFFF_FFFF, 0, "R5");
    expect_rd(1*STR+4, MMASK, "R5");
    // R4 ring while disabled
    step(1, 0, 1, 3, "R4");
    expect_rd(8, 32'h8, "R4");
    expect_rd(12, 0, "R4 pending");
    chk(32'(db_irq[0]), 0, "R4 irq");
    // R6 enable reveals
    step(1, 4, 32'h8, 0, "R6");
    expect_rd(12, 32'h8, "R6");
    chk(32'(db_irq[0]), 1, "R6 irq");
    // R3 bit0 clear no ring, trigger reads 0
    step(1, 0, 2, 4, "R3");
    expect_rd(8, 32'h8, "R3");
    expect_rd(0, 0, "R3 trigger read");
    // R9 out-of-range master
    step(1, 1*STR, 1, 30, "R9");
    expect_rd(1*STR+8, 0, "R9");
    // R7 selective clear, raw read-only
    step(1, 2*STR+4, MMASK, 0, "R7");
    step(1, 2*STR, 1, 0, "R7");
    step(1, 2*STR, 1, 5, "R7");
    step(1, 2*STR, 1, 23, "R7");
    step(1, 2*STR+12, 32'h20, 0, "R7");
    expect_rd(2*STR+12, 32'h0080_0001, "R7");
    step(1, 2*STR+8, 0, 0, "R7");
    expect_rd(2*STR+8, 32'h0080_0001, "R7 raw write ignored");
    // R2 decode holes
    step(1, 4*STR, 1, 1, "R2");
    step(1, 16, 32'hFF, 0, "R2");
    step(1, 3*STR+20, 32'hFF, 0, "R2");
    expect_rd(16, 0, "R2");
    expect_rd(0+4, 32'h8, "R2");
    expect_rd(3*STR+4, 0, "R2");
    expect_rd(3*STR+8, 0, "R2");
    // R6 hide and reveal
    step(1, 4, 0, 0, "R6");
    expect_rd(12, 0, "R6 hidden");
    chk(32'(db_irq[0]), 0, "R6 irq off");
    step(1, 4, 32'h8, 0, "R6");
    expect_rd(12, 32'h8, "R6 revealed");
    // R8 hold
    repeat (5) rd(0, "R8");
    @(negedge clk);
    chk(32'(db_irq[0]), 1, "R8 hold");
    step(1, 12, 32'h8, 0, "R8");
    @(negedge clk);
    chk(32'(db_irq[0]), 0, "R8 cleared");
    // mixed traffic
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], {lfsr[9:8], 3'b0, lfsr[3:2], 2'b0}, {lfsr, lfsr[15:1], 1'b1} ^ (lfsr[4] ? 0 : 32'hFFFF_FFFE),
           int'(lfsr[15:11]), "R6 mixed");
    end
    step(0, 0, 0, 0, "R6");
    @(negedge clk);
    compare();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule